// File: doc/BRIEF.md
# Time-Multiplexed Four-Read Two-Write Register File

This block presents a register file with four read ports and two write ports to a modelled target machine. Its storage offers only two combinational read ports and one write port per host clock. A small sequencer spreads each target cycle over four host clocks: two read phases of two reads each, then one write phase for each write port. The results seen by the target are exactly those of a true four-read, two-write register file that updates once per target cycle.

The surrounding model raises `start_i` for one host clock to begin a target cycle. The block captures every address, enable and write datum on that clock. It stays busy for four host clocks. On the fifth clock it raises `done_o` for one clock. In that same clock the four read results appear on the read data outputs, and they are held there until the next target cycle completes.

Top module: `tgt_regfile_seq`

## Requirements
- R1: While reset is asserted and on the first clock after its release, `busy_o` and `done_o` are low and all four read data outputs are zero.
- R2: A `start_i` sampled high while idle makes `busy_o` high for exactly the next four clocks. `done_o` then goes high for exactly one clock, and `busy_o` is low in that clock.
- R3: The four read outputs shown with `done_o` hold the register contents from before that target cycle. A write issued in the same target cycle, to the same register, is not visible to these reads.
- R4: A write port whose enable is high stores its data into its register. The value can be read in any later target cycle.
- R5: When both write enables are high and both addresses are equal, the register keeps the data of write port b.
- R6: Register 0 always reads as zero, and writes to register 0 are discarded.
- R7: The read data outputs change only in a clock in which `done_o` is high.
- R8: `start_i` is ignored while `busy_o` is high. Address, enable and data inputs are used only as sampled with an accepted start, so later changes to them have no effect.
- R9: A write port whose enable is low leaves every register unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Host clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Begin a target cycle (sampled only while idle) |
| busy_o | output | 1 | A target cycle is in progress |
| done_o | output | 1 | One-clock pulse: target cycle complete, read data updated |
| rd_addr_a | input | ADDR_W | Read port a address |
| rd_addr_b | input | ADDR_W | Read port b address |
| rd_addr_c | input | ADDR_W | Read port c address |
| rd_addr_d | input | ADDR_W | Read port d address |
| rd_data_a | output | DATA_W | Read port a result |
| rd_data_b | output | DATA_W | Read port b result |
| rd_data_c | output | DATA_W | Read port c result |
| rd_data_d | output | DATA_W | Read port d result |
| wr_en_a | input | 1 | Write port a enable |
| wr_addr_a | input | ADDR_W | Write port a address |
| wr_data_a | input | DATA_W | Write port a data |
| wr_en_b | input | 1 | Write port b enable (wins on equal address) |
| wr_addr_b | input | ADDR_W | Write port b address |
| wr_data_b | input | DATA_W | Write port b data |

## Verification
The hardest case to reach is a target cycle that both writes and reads the same register, combined with inputs that change while the sequencer is busy. Such a cycle shows whether the reads really see only the old contents, and whether later input values leak into the cycle. In each target cycle the stimulus scrambles every address, data and enable input and holds `start_i` high during all four busy clocks. Directed cycles point reads at registers written in the same cycle, and set both write ports to one address. Long random runs over a small address range make these collisions frequent.

// File: rtl/tgt_rf_pkg.sv
package tgt_rf_pkg;

  // Host phases used to time-multiplex one target cycle.
  typedef enum logic [2:0] {
    PH_IDLE  = 3'd0,
    PH_RD_LO = 3'd1,
    PH_RD_HI = 3'd2,
    PH_WR_A  = 3'd3,
    PH_WR_B  = 3'd4
  } phase_e;

  localparam int unsigned TGT_READS  = 4;
  localparam int unsigned HOST_READS = 2;

endpackage

// File: rtl/rf_host_store.sv
module rf_host_store #(
  parameter int NUM_REGS = 32,
  parameter int DATA_W   = 32,
  localparam int ADDR_W  = $clog2(NUM_REGS)
) (
  input  logic              clk,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [ADDR_W-1:0] raddr0,
  input  logic [ADDR_W-1:0] raddr1,
  output logic [DATA_W-1:0] rdata0,
  output logic [DATA_W-1:0] rdata1
);

  logic [NUM_REGS-1:0][DATA_W-1:0] cells;

  // Entry 0 is hard-wired to zero; writes to it have no target.
  assign cells[0] = '0;

  for (genvar g = 1; g < NUM_REGS; g++) begin : g_cell
    logic              cell_en;
    logic [DATA_W-1:0] cell_q;

    assign cell_en = we && (waddr == ADDR_W'(g));

    always_ff @(posedge clk) begin
      if (cell_en) begin
        cell_q <= wdata;
      end
    end

    assign cells[g] = cell_q;
  end

  assign rdata0 = cells[raddr0];
  assign rdata1 = cells[raddr1];

endmodule

// File: rtl/rf_phase_ctrl.sv
module rf_phase_ctrl
  import tgt_rf_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   start_i,
  output phase_e phase,
  output logic   accept,
  output logic   busy,
  output logic   done
);

  phase_e phase_q, phase_d;
  logic   done_q, done_d;

  always_comb begin
    phase_d = phase_q;
    unique case (phase_q)
      PH_IDLE:  if (start_i) phase_d = PH_RD_LO;
      PH_RD_LO: phase_d = PH_RD_HI;
      PH_RD_HI: phase_d = PH_WR_A;
      PH_WR_A:  phase_d = PH_WR_B;
      PH_WR_B:  phase_d = PH_IDLE;
      default:  phase_d = PH_IDLE;
    endcase
    done_d = (phase_q == PH_WR_B);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_IDLE;
      done_q  <= 1'b0;
    end else begin
      phase_q <= phase_d;
      done_q  <= done_d;
    end
  end

  assign phase  = phase_q;
  assign accept = (phase_q == PH_IDLE) && start_i;
  assign busy   = (phase_q != PH_IDLE);
  assign done   = done_q;

endmodule

// File: rtl/rf_read_collect.sv
module rf_read_collect
  import tgt_rf_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  phase_e            phase,
  input  logic [DATA_W-1:0] host_rdata0,
  input  logic [DATA_W-1:0] host_rdata1,
  output logic [DATA_W-1:0] out_a,
  output logic [DATA_W-1:0] out_b,
  output logic [DATA_W-1:0] out_c,
  output logic [DATA_W-1:0] out_d
);

  logic [TGT_READS-1:0][DATA_W-1:0] stage_q;
  logic [TGT_READS-1:0][DATA_W-1:0] shown_q;
  logic lo_en, hi_en, publish_en;

  assign lo_en      = (phase == PH_RD_LO);
  assign hi_en      = (phase == PH_RD_HI);
  assign publish_en = (phase == PH_WR_B);

  // Staging: no reset needed, always loaded before it is published.
  always_ff @(posedge clk) begin
    if (lo_en) begin
      stage_q[0] <= host_rdata0;
      stage_q[1] <= host_rdata1;
    end
    if (hi_en) begin
      stage_q[2] <= host_rdata0;
      stage_q[3] <= host_rdata1;
    end
  end

  // Target-visible results: updated once per target cycle.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shown_q <= '0;
    end else if (publish_en) begin
      shown_q <= stage_q;
    end
  end

  assign out_a = shown_q[0];
  assign out_b = shown_q[1];
  assign out_c = shown_q[2];
  assign out_d = shown_q[3];

endmodule

// File: rtl/tgt_regfile_seq.sv
module tgt_regfile_seq
  import tgt_rf_pkg::*;
#(
  parameter int NUM_REGS = 32,
  parameter int DATA_W   = 32,
  localparam int ADDR_W  = $clog2(NUM_REGS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  output logic              busy_o,
  output logic              done_o,
  input  logic [ADDR_W-1:0] rd_addr_a,
  input  logic [ADDR_W-1:0] rd_addr_b,
  input  logic [ADDR_W-1:0] rd_addr_c,
  input  logic [ADDR_W-1:0] rd_addr_d,
  output logic [DATA_W-1:0] rd_data_a,
  output logic [DATA_W-1:0] rd_data_b,
  output logic [DATA_W-1:0] rd_data_c,
  output logic [DATA_W-1:0] rd_data_d,
  input  logic              wr_en_a,
  input  logic [ADDR_W-1:0] wr_addr_a,
  input  logic [DATA_W-1:0] wr_data_a,
  input  logic              wr_en_b,
  input  logic [ADDR_W-1:0] wr_addr_b,
  input  logic [DATA_W-1:0] wr_data_b
);

  phase_e phase;
  logic   accept;

  // Request captured on an accepted start.
  logic [TGT_READS-1:0][ADDR_W-1:0] req_raddr_q;
  logic                             req_wen_a_q, req_wen_b_q;
  logic [ADDR_W-1:0]                req_waddr_a_q, req_waddr_b_q;
  logic [DATA_W-1:0]                req_wdata_a_q, req_wdata_b_q;

  always_ff @(posedge clk) begin
    if (accept) begin
      req_raddr_q[0] <= rd_addr_a;
      req_raddr_q[1] <= rd_addr_b;
      req_raddr_q[2] <= rd_addr_c;
      req_raddr_q[3] <= rd_addr_d;
      req_waddr_a_q  <= wr_addr_a;
      req_waddr_b_q  <= wr_addr_b;
      req_wdata_a_q  <= wr_data_a;
      req_wdata_b_q  <= wr_data_b;
    end
  end

  // Enables carry reset so no stray write can occur after reset.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_wen_a_q <= 1'b0;
      req_wen_b_q <= 1'b0;
    end else if (accept) begin
      req_wen_a_q <= wr_en_a;
      req_wen_b_q <= wr_en_b;
    end
  end

  // Host port steering per phase.
  logic [ADDR_W-1:0] host_raddr0, host_raddr1;
  logic [DATA_W-1:0] host_rdata0, host_rdata1;
  logic              host_we;
  logic [ADDR_W-1:0] host_waddr;
  logic [DATA_W-1:0] host_wdata;

  always_comb begin
    if (phase == PH_RD_HI) begin
      host_raddr0 = req_raddr_q[2];
      host_raddr1 = req_raddr_q[3];
    end else begin
      host_raddr0 = req_raddr_q[0];
      host_raddr1 = req_raddr_q[1];
    end
    if (phase == PH_WR_B) begin
      host_we    = req_wen_b_q;
      host_waddr = req_waddr_b_q;
      host_wdata = req_wdata_b_q;
    end else begin
      host_we    = req_wen_a_q && (phase == PH_WR_A);
      host_waddr = req_waddr_a_q;
      host_wdata = req_wdata_a_q;
    end
  end

  rf_phase_ctrl u_ctrl (
    .clk     (clk),
    .rst_n   (rst_n),
    .start_i (start_i),
    .phase   (phase),
    .accept  (accept),
    .busy    (busy_o),
    .done    (done_o)
  );

  rf_host_store #(
    .NUM_REGS (NUM_REGS),
    .DATA_W   (DATA_W)
  ) u_store (
    .clk    (clk),
    .we     (host_we),
    .waddr  (host_waddr),
    .wdata  (host_wdata),
    .raddr0 (host_raddr0),
    .raddr1 (host_raddr1),
    .rdata0 (host_rdata0),
    .rdata1 (host_rdata1)
  );

  rf_read_collect #(
    .DATA_W (DATA_W)
  ) u_collect (
    .clk         (clk),
    .rst_n       (rst_n),
    .phase       (phase),
    .host_rdata0 (host_rdata0),
    .host_rdata1 (host_rdata1),
    .out_a       (rd_data_a),
    .out_b       (rd_data_b),
    .out_c       (rd_data_c),
    .out_d       (rd_data_d)
  );

endmodule

// File: rtl/rf_seq_checker.sv
module rf_seq_checker #(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 5
) (
  input logic              clk,
  input logic              rst_n,
  input logic              start_i,
  input logic              busy_o,
  input logic              done_o,
  input logic [DATA_W-1:0] rd_data_a,
  input logic [DATA_W-1:0] rd_data_b,
  input logic [DATA_W-1:0] rd_data_c,
  input logic [DATA_W-1:0] rd_data_d,
  input logic [ADDR_W-1:0] host_raddr0,
  input logic [ADDR_W-1:0] host_raddr1,
  input logic [DATA_W-1:0] host_rdata0,
  input logic [DATA_W-1:0] host_rdata1
);

  p_done_single_r2: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  p_done_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> !busy_o);

  p_four_busy_r2: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> ($past(busy_o, 1) && $past(busy_o, 4) && !$past(busy_o, 5)));

  p_hold_outputs_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !done_o |-> ($stable(rd_data_a) && $stable(rd_data_b)
                 && $stable(rd_data_c) && $stable(rd_data_d)));

  p_zero_port0_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (host_raddr0 == '0) |-> (host_rdata0 == '0));

  p_zero_port1_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (host_raddr1 == '0) |-> (host_rdata1 == '0));

  p_no_restart_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && start_i) |=> (busy_o || done_o));

endmodule

bind tgt_regfile_seq rf_seq_checker #(
  .DATA_W (DATA_W),
  .ADDR_W (ADDR_W)
) u_seq_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .start_i     (start_i),
  .busy_o      (busy_o),
  .done_o      (done_o),
  .rd_data_a   (rd_data_a),
  .rd_data_b   (rd_data_b),
  .rd_data_c   (rd_data_c),
  .rd_data_d   (rd_data_d),
  .host_raddr0 (host_raddr0),
  .host_raddr1 (host_raddr1),
  .host_rdata0 (host_rdata0),
  .host_rdata1 (host_rdata1)
);

// File: tb/tb_tgt_regfile_seq.sv
module tb_tgt_regfile_seq;

  localparam int NR = 32;
  localparam int DW = 32;
  localparam int AW = 5;

  logic clk, rst_n, start_i, busy_o, done_o;
  logic [AW-1:0] rd_addr_a, rd_addr_b, rd_addr_c, rd_addr_d;
  logic [DW-1:0] rd_data_a, rd_data_b, rd_data_c, rd_data_d;
  logic          wr_en_a, wr_en_b;
  logic [AW-1:0] wr_addr_a, wr_addr_b;
  logic [DW-1:0] wr_data_a, wr_data_b;

  tgt_regfile_seq dut (.*);

  initial clk = 1'b0;
  always #10 clk = ~clk;

  int checks = 0;
  int errors = 0;

  // Behavioural reference state.
  logic [DW-1:0] model [NR];
  logic [DW-1:0] exp_rd [4];
  logic [AW-1:0] ra [4];
  logic          we_a, we_b;
  logic [AW-1:0] wa_a, wa_b;
  logic [DW-1:0] wd_a, wd_b;
  logic          hung = 1'b0;

  task automatic chk(input logic ok, input string req, input string what,
                     input logic [DW-1:0] act, input logic [DW-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic chk_outputs(input string req);
    chk(rd_data_a === exp_rd[0], req, "rd_data_a", rd_data_a, exp_rd[0]);
    chk(rd_data_b === exp_rd[1], req, "rd_data_b", rd_data_b, exp_rd[1]);
    chk(rd_data_c === exp_rd[2], req, "rd_data_c", rd_data_c, exp_rd[2]);
    chk(rd_data_d === exp_rd[3], req, "rd_data_d", rd_data_d, exp_rd[3]);
  endtask

  task automatic scramble();
    rd_addr_a = AW'($urandom); rd_addr_b = AW'($urandom);
    rd_addr_c = AW'($urandom); rd_addr_d = AW'($urandom);
    wr_en_a = 1'b1; wr_en_b = 1'b1;
    wr_addr_a = AW'($urandom); wr_addr_b = AW'($urandom);
    wr_data_a = $urandom; wr_data_b = $urandom;
  endtask

  // One target cycle; called right after a negedge with the DUT idle.
  task automatic tgt_cycle(input string req);
    rd_addr_a = ra[0]; rd_addr_b = ra[1]; rd_addr_c = ra[2]; rd_addr_d = ra[3];
    wr_en_a = we_a; wr_addr_a = wa_a; wr_data_a = wd_a;
    wr_en_b = we_b; wr_addr_b = wa_b; wr_data_b = wd_b;
    start_i = 1'b1;
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      scramble();          // R8: later inputs and starts must not matter
      start_i = 1'b1;
      chk(busy_o === 1'b1, "R2", "busy during phase", {31'd0, busy_o}, 32'd1);
      chk(done_o === 1'b0, "R2", "done during phase", {31'd0, done_o}, 32'd0);
      chk_outputs("R7");
    end
    @(negedge clk);
    start_i = 1'b0;
    for (int i = 0; i < 4; i++) exp_rd[i] = (ra[i] == 0) ? '0 : model[ra[i]];
    chk(done_o === 1'b1, "R2", "done pulse", {31'd0, done_o}, 32'd1);
    chk(busy_o === 1'b0, "R8", "busy after four phases", {31'd0, busy_o}, 32'd0);
    chk_outputs(req);
    if (we_a && wa_a != 0) model[wa_a] = wd_a;
    if (we_b && wa_b != 0) model[wa_b] = wd_b;
    @(negedge clk);
    chk(done_o === 1'b0, "R2", "done single", {31'd0, done_o}, 32'd0);
    chk(busy_o === 1'b0, "R8", "idle after done", {31'd0, busy_o}, 32'd0);
    chk_outputs("R7");
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    hung = 1'b1;
    errors++;
    checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0; start_i = 1'b0;
    for (int i = 0; i < 4; i++) begin ra[i] = '0; exp_rd[i] = '0; end
    for (int i = 0; i < NR; i++) model[i] = '0;
    we_a = 0; we_b = 0; wa_a = 0; wa_b = 0; wd_a = 0; wd_b = 0;
    rd_addr_a = 0; rd_addr_b = 0; rd_addr_c = 0; rd_addr_d = 0;
    wr_en_a = 0; wr_en_b = 0; wr_addr_a = 0; wr_addr_b = 0;
    wr_data_a = 0; wr_data_b = 0;
    repeat (3) @(negedge clk);
    chk(busy_o === 1'b0, "R1", "busy in reset", {31'd0, busy_o}, 32'd0);
    chk(done_o === 1'b0, "R1", "done in reset", {31'd0, done_o}, 32'd0);
    chk_outputs("R1");
    rst_n = 1'b1;
    @(negedge clk);
    chk(busy_o === 1'b0, "R1", "busy after reset", {31'd0, busy_o}, 32'd0);
    chk_outputs("R1");

    // R4: fill every register, two per target cycle.
    for (int r = 1; r < NR; r += 2) begin
      for (int i = 0; i < 4; i++) ra[i] = '0;
      we_a = 1; wa_a = AW'(r); wd_a = 32'hA500_0000 + r;
      we_b = (r + 1 < NR); wa_b = AW'(r + 1); wd_b = 32'h5A00_0000 + r + 1;
      tgt_cycle("R4");
    end
    we_a = 0; we_b = 0;
    ra[0] = 1; ra[1] = 2; ra[2] = 17; ra[3] = 31;
    tgt_cycle("R4");

    // R3: write and read the same register in one target cycle.
    ra[0] = 5; ra[1] = 6; ra[2] = 5; ra[3] = 6;
    we_a = 1; wa_a = 5; wd_a = 32'hDEAD_0005;
    we_b = 1; wa_b = 6; wd_b = 32'hBEEF_0006;
    tgt_cycle("R3");
    we_a = 0; we_b = 0;
    tgt_cycle("R4");

    // R5: both ports on one register, port b wins.
    we_a = 1; wa_a = 9; wd_a = 32'h1111_1111;
    we_b = 1; wa_b = 9; wd_b = 32'h2222_2222;
    ra[0] = 9; ra[1] = 9; ra[2] = 0; ra[3] = 9;
    tgt_cycle("R3");
    we_a = 0; we_b = 0;
    tgt_cycle("R5");

    // R6: register 0 writes discarded, reads zero.
    we_a = 1; wa_a = 0; wd_a = 32'hFFFF_FFFF;
    we_b = 1; wa_b = 0; wd_b = 32'h1234_5678;
    ra[0] = 0; ra[1] = 0; ra[2] = 0; ra[3] = 0;
    tgt_cycle("R6");
    we_a = 0; we_b = 0;
    tgt_cycle("R6");

    // R9: disabled ports change nothing.
    we_a = 0; wa_a = 12; wd_a = 32'hCAFE_0012;
    we_b = 0; wa_b = 13; wd_b = 32'hCAFE_0013;
    ra[0] = 12; ra[1] = 13; ra[2] = 12; ra[3] = 13;
    tgt_cycle("R9");
    tgt_cycle("R9");

    // R3 R4 R5 R8: random cycles over a narrow address range.
    for (int n = 0; n < 300; n++) begin
      for (int i = 0; i < 4; i++) ra[i] = AW'($urandom_range(0, 3));
      we_a = 1'($urandom); wa_a = AW'($urandom_range(0, 3)); wd_a = $urandom;
      we_b = 1'($urandom); wa_b = AW'($urandom_range(0, 3)); wd_b = $urandom;
      tgt_cycle("R3");
    end

    if (!hung) begin
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule